// File: doc/BRIEF.md
# SCSI Controller Command Decoder and Interrupt Status

This block sits behind the byte-wide register port of a SCSI bus controller. Software writes a 7-bit opcode, with bit 7 as a DMA qualifier, into the command register. The block decodes it and updates four things: the status register, the interrupt-cause register, the sequence-step register and the flags register. It drives a level interrupt line that always equals status bit 7.

Selection commands look up the target ID, held in bits 2:0 of the bus-ID register, in a device-present mask. An absent target produces a disconnect interrupt. A present target completes the selection. The stop variant of select leaves the block in a command-capture mode, and a later transfer command ends that mode.

Reading the interrupt-cause register has side effects. It returns the old cause, clears the cause, clears terminal count, lowers the interrupt and sets the sequence step to 4. Opcodes the block does not know leave the status state untouched and set a sticky illegal-command flag.

Top module: `cmdec_top`

## Requirements
- R1: After `rst`, and after a write of opcode 0x02, the registers hold these values: status 0, cause 0, sequence step 0, flags 0, bus ID 0, command 0, configuration-1 7 and ID register 0x04. After either event `irq` is 0 and `cap_mode` is 0.
- R2: A read of offset 5 (cause) returns the pre-read cause on `rdata` one cycle later. The same read clears the cause, status bit 4 (terminal count) and status bit 7, and sets the sequence step to 4.
- R3: The register offsets are:
  - 3: command
  - 4: status on read, bus ID on write
  - 5: cause
  - 6: sequence step
  - 7: flags
  - 8: configuration-1
  - 14: ID register

  Other offsets read 0. `irq` always equals status bit 7.
- R4: Opcode 0x01 (flush) sets the cause to 0x08 and clears the sequence step and the flags. It leaves `irq` unchanged.
- R5: Opcode 0x03 (bus reset) sets the cause to 0x80. It raises `irq` only when configuration-1 bit 6 is 0.
- R6: Opcodes 0x41, 0x42 and 0x43 with `dev_present[busid[2:0]]` equal to 0 set the status to 0x80, the cause to 0x20 (disconnect) and the sequence step to 0.
- R7: Opcodes 0x41 and 0x42 on a present target set the cause to 0x18 (bus service plus function complete) and the sequence step to 4. They raise `irq` and keep status bits 6:0.
- R8: Opcode 0x43 on a present target sets the status to 0x92, the cause to 0x18 and the sequence step to 4, and turns `cap_mode` on.
- R9: Opcode 0x10 (transfer) behaves in one of three ways:
  - With `cap_mode` on: it clears `cap_mode`, sets the cause to 0x18 and the sequence step to 4, and raises `irq`.
  - With `cap_mode` off and bit 7 set: it clears status bit 4.
  - With `cap_mode` off and bit 7 clear: it has no effect.
- R10: Opcode 0x11 sets the cause to 0x08. Without bit 7 it ORs 0x87 into the status and sets the flags to 2. With bit 7 it sets the status to 0x97 and the sequence step to 4.
- R11: Opcode 0x12 sets the cause to 0x20 and the sequence step to 0, and raises `irq`. Without bit 7 it sets the flags to 2. With bit 7 it sets the status to 0x93.
- R12: Opcode 0x44 clears the cause. Opcodes 0x00 and 0x1A change nothing except the command readback.
- R13: Any other opcode leaves the status, cause, sequence step, flags, `irq` and `cap_mode` unchanged. It sets `illegal_cmd`, which stays set until `rst`.
- R14: A write to offset 0 or 1 (transfer count bytes) clears status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| dev_present | input | 8 | One bit per target ID, 1 = device present |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt, equals status bit 7 |
| cap_mode | output | 1 | Command-capture mode after select-and-stop |
| illegal_cmd | output | 1 | Sticky flag for an unknown opcode |

## Verification
Every write and every read side effect takes effect at the clock edge that samples the strobe. `irq`, `cap_mode` and `illegal_cmd` therefore hold their new values from the next cycle. `rdata` is also registered and holds the pre-read value in that same cycle. The bench raises a strobe at a falling edge and drops it at the next falling edge, then compares every output there, after exactly one rising edge. A bench-side register model, updated in the same order as the strobes, supplies the expected values.

// File: rtl/cmdec_pkg.sv
package cmdec_pkg;

    localparam int REG_W = 8;

    // register offsets
    localparam logic [3:0] OFS_TCLO  = 4'h0;
    localparam logic [3:0] OFS_TCMID = 4'h1;
    localparam logic [3:0] OFS_CMD   = 4'h3;
    localparam logic [3:0] OFS_STAT  = 4'h4;
    localparam logic [3:0] OFS_CAUSE = 4'h5;
    localparam logic [3:0] OFS_SEQ   = 4'h6;
    localparam logic [3:0] OFS_FLAGS = 4'h7;
    localparam logic [3:0] OFS_CFG1  = 4'h8;
    localparam logic [3:0] OFS_HIID  = 4'hE;

    // cause bits
    localparam logic [REG_W-1:0] CS_FUNC_DONE = 8'h08;
    localparam logic [REG_W-1:0] CS_BUS_SVC   = 8'h10;
    localparam logic [REG_W-1:0] CS_DISCON    = 8'h20;
    localparam logic [REG_W-1:0] CS_BUS_RST   = 8'h80;

    // status bits
    localparam int ST_IRQ_BIT = 7;
    localparam int ST_TC_BIT  = 4;

    // reset values
    localparam logic [REG_W-1:0] CFG1_RST = 8'h07;
    localparam logic [REG_W-1:0] HIID_RST = 8'h04;
    localparam int CFG1_MUTE_BIT = 6;

    localparam logic [REG_W-1:0] SEQ_DONE = 8'h04;

    typedef enum logic [3:0] {
        CK_NOP,
        CK_FLUSH,
        CK_RESET,
        CK_BUSRST,
        CK_XFER,
        CK_INIT_DONE,
        CK_MSG_OK,
        CK_SET_ATN,
        CK_SEL_PLAIN,
        CK_SEL_ATN,
        CK_SEL_STOP,
        CK_EN_SEL,
        CK_ILLEGAL
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e kind;
        logic      dma;
    } cmd_dec_t;

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] cause;
        logic [REG_W-1:0] seq;
        logic [REG_W-1:0] flags;
        logic [REG_W-1:0] cfg1;
        logic [REG_W-1:0] hiid;
        logic [REG_W-1:0] busid;
        logic [REG_W-1:0] cmd;
    } reg_file_t;

    function automatic reg_file_t reg_reset_value();
        reg_file_t r;
        r       = '0;
        r.cfg1  = CFG1_RST;
        r.hiid  = HIID_RST;
        return r;
    endfunction

    function automatic cmd_kind_e kind_of(input logic [6:0] op);
        cmd_kind_e k;
        case (op)
            7'h00:   k = CK_NOP;
            7'h01:   k = CK_FLUSH;
            7'h02:   k = CK_RESET;
            7'h03:   k = CK_BUSRST;
            7'h10:   k = CK_XFER;
            7'h11:   k = CK_INIT_DONE;
            7'h12:   k = CK_MSG_OK;
            7'h1A:   k = CK_SET_ATN;
            7'h41:   k = CK_SEL_PLAIN;
            7'h42:   k = CK_SEL_ATN;
            7'h43:   k = CK_SEL_STOP;
            7'h44:   k = CK_EN_SEL;
            default: k = CK_ILLEGAL;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/cmdec_decode.sv
module cmdec_decode
    import cmdec_pkg::*;
(
    input  logic [REG_W-1:0] op_byte,
    output cmd_dec_t         dec
);
    always_comb begin
        dec.kind = kind_of(op_byte[REG_W-2:0]);
        dec.dma  = op_byte[REG_W-1];
    end
endmodule

// File: rtl/cmdec_target_check.sv
module cmdec_target_check #(
    parameter int ID_W    = 3,
    parameter int NUM_DEV = 1 << ID_W
) (
    input  logic [7:0]         busid,
    input  logic [NUM_DEV-1:0] dev_present,
    output logic               present
);
    logic [ID_W-1:0] tgt;
    logic [NUM_DEV-1:0] hit;

    assign tgt = busid[ID_W-1:0];

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_slot
        assign hit[i] = (tgt == ID_W'(i)) && dev_present[i];
    end

    assign present = |hit;
endmodule

// File: rtl/cmdec_regs.sv
module cmdec_regs
    import cmdec_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  cmd_dec_t          dec,
    input  logic              tgt_present,
    output logic [REG_W-1:0]  busid,
    output logic [REG_W-1:0]  rdata,
    output logic              irq,
    output logic              cap_mode,
    output logic              illegal_cmd
);
    reg_file_t cur, nxt;
    logic      cap_q, cap_n;
    logic      ill_q, ill_n;
    logic [REG_W-1:0] rd_mux;
    logic      cause_rd, cmd_wr;

    assign cause_rd = rd_en && (addr == OFS_CAUSE);
    assign cmd_wr   = wr_en && (addr == OFS_CMD);

    always_comb begin
        case (addr)
            OFS_CMD:   rd_mux = cur.cmd;
            OFS_STAT:  rd_mux = cur.stat;
            OFS_CAUSE: rd_mux = cur.cause;
            OFS_SEQ:   rd_mux = cur.seq;
            OFS_FLAGS: rd_mux = cur.flags;
            OFS_CFG1:  rd_mux = cur.cfg1;
            OFS_HIID:  rd_mux = cur.hiid;
            default:   rd_mux = '0;
        endcase
    end

    always_comb begin
        nxt   = cur;
        cap_n = cap_q;
        ill_n = ill_q;

        if (cause_rd) begin
            nxt.cause            = '0;
            nxt.stat[ST_TC_BIT]  = 1'b0;
            nxt.stat[ST_IRQ_BIT] = 1'b0;
            nxt.seq              = SEQ_DONE;
        end

        if (wr_en) begin
            case (addr)
                OFS_TCLO, OFS_TCMID: nxt.stat[ST_TC_BIT] = 1'b0;
                OFS_STAT:            nxt.busid = wdata;
                OFS_CFG1:            nxt.cfg1  = wdata;
                OFS_HIID:            nxt.hiid  = wdata;
                OFS_CMD: begin
                    nxt.cmd = wdata;
                    case (dec.kind)
                        CK_FLUSH: begin
                            nxt.cause = CS_FUNC_DONE;
                            nxt.seq   = '0;
                            nxt.flags = '0;
                        end
                        CK_RESET: begin
                            nxt   = reg_reset_value();
                            cap_n = 1'b0;
                        end
                        CK_BUSRST: begin
                            nxt.cause = CS_BUS_RST;
                            if (!cur.cfg1[CFG1_MUTE_BIT])
                                nxt.stat[ST_IRQ_BIT] = 1'b1;
                        end
                        CK_XFER: begin
                            if (cap_q) begin
                                cap_n                = 1'b0;
                                nxt.cause            = CS_BUS_SVC | CS_FUNC_DONE;
                                nxt.seq              = SEQ_DONE;
                                nxt.stat[ST_IRQ_BIT] = 1'b1;
                            end else if (dec.dma) begin
                                nxt.stat[ST_TC_BIT] = 1'b0;
                            end
                        end
                        CK_INIT_DONE: begin
                            if (dec.dma) begin
                                nxt.stat = 8'h97;
                                nxt.seq  = SEQ_DONE;
                            end else begin
                                nxt.stat  = nxt.stat | 8'h87;
                                nxt.flags = 8'h02;
                            end
                            nxt.cause = CS_FUNC_DONE;
                        end
                        CK_MSG_OK: begin
                            if (dec.dma)
                                nxt.stat = 8'h93;
                            else begin
                                nxt.flags            = 8'h02;
                                nxt.stat[ST_IRQ_BIT] = 1'b1;
                            end
                            nxt.cause = CS_DISCON;
                            nxt.seq   = '0;
                        end
                        CK_SEL_PLAIN, CK_SEL_ATN, CK_SEL_STOP: begin
                            if (!tgt_present) begin
                                nxt.stat  = 8'h80;
                                nxt.cause = CS_DISCON;
                                nxt.seq   = '0;
                            end else if (dec.kind == CK_SEL_STOP) begin
                                nxt.stat  = 8'h92;
                                nxt.cause = CS_BUS_SVC | CS_FUNC_DONE;
                                nxt.seq   = SEQ_DONE;
                                cap_n     = 1'b1;
                            end else begin
                                nxt.cause            = CS_BUS_SVC | CS_FUNC_DONE;
                                nxt.seq              = SEQ_DONE;
                                nxt.stat[ST_IRQ_BIT] = 1'b1;
                            end
                        end
                        CK_EN_SEL: nxt.cause = '0;
                        CK_ILLEGAL: ill_n = 1'b1;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= reg_reset_value();
            cap_q <= 1'b0;
            ill_q <= 1'b0;
            rdata <= '0;
        end else begin
            cur   <= nxt;
            cap_q <= cap_n;
            ill_q <= ill_n;
            if (rd_en)
                rdata <= rd_mux;
        end
    end

    assign busid       = cur.busid;
    assign irq         = cur.stat[ST_IRQ_BIT];
    assign cap_mode    = cap_q;
    assign illegal_cmd = ill_q;

    AST_CAUSE_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cause_rd && !wr_en) |=> (cur.cause == '0 && !irq && cur.seq == SEQ_DONE)); // R2

    AST_BUSRST_MUTED: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && dec.kind == CK_BUSRST && cur.cfg1[CFG1_MUTE_BIT] && !irq && !rd_en)
        |=> !irq); // R5

    AST_ABSENT_SELECT: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !tgt_present && !rd_en &&
         (dec.kind == CK_SEL_PLAIN || dec.kind == CK_SEL_ATN || dec.kind == CK_SEL_STOP))
        |=> (cur.cause == CS_DISCON && cur.seq == '0 && irq)); // R6

    AST_CAPTURE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_mode) |-> $past(cmd_wr && dec.kind == CK_SEL_STOP && tgt_present)); // R8

    AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (rst)
        illegal_cmd |=> illegal_cmd); // R13

    AST_ILLEGAL_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && dec.kind == CK_ILLEGAL && !rd_en) |=> ($stable(irq) && $stable(cap_mode))); // R13
endmodule

// File: rtl/cmdec_top.sv
module cmdec_top
    import cmdec_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int ID_W    = 3,
    parameter int NUM_DEV = 1 << ID_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_DEV-1:0] dev_present,
    output logic [REG_W-1:0]   rdata,
    output logic               irq,
    output logic               cap_mode,
    output logic               illegal_cmd
);
    cmd_dec_t         dec;
    logic             tgt_present;
    logic [REG_W-1:0] busid;

    cmdec_decode u_decode (
        .op_byte (wdata),
        .dec     (dec)
    );

    cmdec_target_check #(.ID_W(ID_W), .NUM_DEV(NUM_DEV)) u_tgt (
        .busid       (busid),
        .dev_present (dev_present),
        .present     (tgt_present)
    );

    cmdec_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .dec         (dec),
        .tgt_present (tgt_present),
        .busid       (busid),
        .rdata       (rdata),
        .irq         (irq),
        .cap_mode    (cap_mode),
        .illegal_cmd (illegal_cmd)
    );
endmodule

// File: tb/cmdec_top_tb.sv
module cmdec_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic       clk = 1'b0;
    logic       rst, wr_en, rd_en;
    logic [3:0] addr;
    logic [7:0] wdata, dev_present, rdata;
    logic       irq, cap_mode, illegal_cmd;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference model state
    logic [7:0] m_stat, m_cause, m_seq, m_flags, m_cfg1, m_hiid, m_busid, m_cmd;
    logic       m_cap, m_ill;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdec_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .dev_present(dev_present), .rdata(rdata),
        .irq(irq), .cap_mode(cap_mode), .illegal_cmd(illegal_cmd)
    );

    task automatic m_reset_regs();
        m_stat = 0; m_cause = 0; m_seq = 0; m_flags = 0;
        m_cfg1 = 8'h07; m_hiid = 8'h04; m_busid = 0; m_cmd = 0; m_cap = 0;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [7:0] op);
        case (op[6:0])
            7'h00, 7'h1A, 7'h44: return "R12";
            7'h01: return "R4";
            7'h02: return "R1";
            7'h03: return "R5";
            7'h10: return "R9";
            7'h11: return "R10";
            7'h12: return "R11";
            7'h41, 7'h42, 7'h43: return dev_present[m_busid[2:0]] ? (op[6:0] == 7'h43 ? "R8" : "R7") : "R6";
            default: return "R13";
        endcase
    endfunction

    task automatic m_write(input logic [3:0] a, input logic [7:0] d);
        logic pres;
        pres = dev_present[m_busid[2:0]];
        case (a)
            4'h0, 4'h1: m_stat[4] = 1'b0;
            4'h4: m_busid = d;
            4'h8: m_cfg1 = d;
            4'hE: m_hiid = d;
            4'h3: begin
                m_cmd = d;
                case (d[6:0])
                    7'h00, 7'h1A: ;
                    7'h01: begin m_cause = 8'h08; m_seq = 0; m_flags = 0; end
                    7'h02: m_reset_regs();
                    7'h03: begin m_cause = 8'h80; if (!m_cfg1[6]) m_stat[7] = 1'b1; end
                    7'h10: begin
                        if (m_cap) begin
                            m_cap = 0; m_cause = 8'h18; m_seq = 8'h04; m_stat[7] = 1'b1;
                        end else if (d[7]) m_stat[4] = 1'b0;
                    end
                    7'h11: begin
                        if (d[7]) begin m_stat = 8'h97; m_seq = 8'h04; end
                        else begin m_stat = m_stat | 8'h87; m_flags = 8'h02; end
                        m_cause = 8'h08;
                    end
                    7'h12: begin
                        if (d[7]) m_stat = 8'h93;
                        else begin m_flags = 8'h02; m_stat[7] = 1'b1; end
                        m_cause = 8'h20; m_seq = 0;
                    end
                    7'h41, 7'h42, 7'h43: begin
                        if (!pres) begin m_stat = 8'h80; m_cause = 8'h20; m_seq = 0; end
                        else if (d[6:0] == 7'h43) begin
                            m_stat = 8'h92; m_cause = 8'h18; m_seq = 8'h04; m_cap = 1'b1;
                        end else begin
                            m_cause = 8'h18; m_seq = 8'h04; m_stat[7] = 1'b1;
                        end
                    end
                    7'h44: m_cause = 0;
                    default: m_ill = 1'b1;
                endcase
            end
            default: ;
        endcase
    endtask

    task automatic m_read(input logic [3:0] a, output logic [7:0] v);
        case (a)
            4'h3: v = m_cmd;
            4'h4: v = m_stat;
            4'h5: v = m_cause;
            4'h6: v = m_seq;
            4'h7: v = m_flags;
            4'h8: v = m_cfg1;
            4'hE: v = m_hiid;
            default: v = 0;
        endcase
        if (a == 4'h5) begin
            m_cause = 0; m_stat[4] = 0; m_stat[7] = 0; m_seq = 8'h04;
        end
    endtask

    task automatic check_lines(input string tag);
        check({tag, "/R3 irq"}, {7'b0, irq}, {7'b0, m_stat[7]});
        check({tag, " cap_mode"}, {7'b0, cap_mode}, {7'b0, m_cap});
        check({tag, " illegal"}, {7'b0, illegal_cmd}, {7'b0, m_ill});
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        m_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
        check_lines(tag);
    endtask

    task automatic do_read(input logic [3:0] a, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        m_read(a, exp);
        @(negedge clk);
        rd_en = 1'b0;
        check({tag, " rdata"}, rdata, exp);
        check_lines(tag);
    endtask

    task automatic read_all(input string tag);
        do_read(4'h4, tag); do_read(4'h6, tag); do_read(4'h7, tag);
        do_read(4'h3, tag); do_read(4'h8, tag); do_read(4'hE, tag);
        do_read(4'h5, tag);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] op;
        logic [7:0] legal [12] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h11,
                                   8'h12, 8'h1A, 8'h41, 8'h42, 8'h43, 8'h44};
        void'($urandom(32'h5EED_0C1D));
        rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        dev_present = 8'b1010_0110;
        m_reset_regs(); m_ill = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_lines("R1");
        read_all("R1");

        // bus reset, interrupt enabled then muted
        do_write(4'h3, 8'h03, "R5");
        do_read(4'h5, "R2");
        do_read(4'h6, "R2");
        do_write(4'h8, 8'h47, "R5");
        do_write(4'h3, 8'h03, "R5");
        do_read(4'h5, "R5");
        do_write(4'h8, 8'h07, "R5");

        // flush
        do_write(4'h3, 8'h01, "R4");
        read_all("R4");

        // absent target select
        do_write(4'h4, 8'h00, "R6");
        do_write(4'h3, 8'h42, "R6");
        read_all("R6");

        // present target select-and-stop, then TC clear, then transfer
        do_write(4'h4, 8'h01, "R8");
        do_write(4'h3, 8'h43, "R8");
        do_read(4'h4, "R8");
        do_write(4'h0, 8'h12, "R14");
        do_read(4'h4, "R14");
        do_write(4'h3, 8'h10, "R9");
        read_all("R9");

        // plain select on present target, DMA transfer outside capture
        do_write(4'h3, 8'h43, "R8");
        do_read(4'h5, "R2");
        do_write(4'h3, 8'h10, "R9");
        do_write(4'h3, 8'h41, "R7");
        read_all("R7");
        do_write(4'h3, 8'h43, "R8");
        do_write(4'h3, 8'h90, "R9");
        do_write(4'h3, 8'h90, "R9");
        do_read(4'h4, "R9");

        // initiator complete and message accepted, both flavours
        do_write(4'h3, 8'h11, "R10"); read_all("R10");
        do_write(4'h3, 8'h91, "R10"); read_all("R10");
        do_write(4'h3, 8'h12, "R11"); read_all("R11");
        do_write(4'h3, 8'h92, "R11"); read_all("R11");

        // enable selection, NOP, set ATN
        do_write(4'h3, 8'h03, "R12");
        do_write(4'h3, 8'h44, "R12");
        do_write(4'h3, 8'h1A, "R12");
        do_write(4'h3, 8'h00, "R12");
        read_all("R12");

        // illegal opcode
        do_write(4'h3, 8'h03, "R13");
        do_write(4'h3, 8'h55, "R13");
        read_all("R13");

        // chip reset command
        do_write(4'h8, 8'h40, "R1");
        do_write(4'h3, 8'h43, "R1");
        do_write(4'h3, 8'h02, "R1");
        read_all("R1");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (i % 400 == 0) dev_present = 8'($urandom());
            if (sel < 4) begin
                if ($urandom_range(0, 7) == 0) op = 8'($urandom());
                else op = legal[$urandom_range(0, 11)] | ($urandom_range(0, 1) ? 8'h80 : 8'h00);
                do_write(4'h3, op, tag_of(op));
            end else if (sel == 4) begin
                do_write(4'h4, 8'($urandom()), "R6");
            end else if (sel == 5) begin
                do_write(4'h8, {1'b0, 1'($urandom()), 6'h07}, "R5");
            end else if (sel == 6) begin
                do_write(4'($urandom_range(0, 1)), 8'($urandom()), "R14");
            end else begin
                do_read(4'($urandom()), "R3");
            end
        end

        done = 1'b1;
        summary();
    end
endmodule